// File: doc/BRIEF.md
# Turbo Bus Write-Replay Arbiter

This block couples a fast processor, which runs from its own zero-wait memory, to a slow host bus clocked at about 1 MHz. A video controller also uses that bus and takes whole slow cycles for display DMA. Every write from the fast core is placed in a short on-card queue. The block then plays the writes back onto the host bus in issue order, one per slow cycle. Playback happens only on a slow-cycle edge where the DMA-busy flag is clear. Because the queue drains one write per slow cycle, writes to the I/O window reach the host at its native cadence.

Reads outside the I/O window are served by local memory and do not wait. A read inside the window (0xD000–0xDFFF) holds the core while the queue empties completely. The read is then performed on the host bus and its data is handed back. A speed select paces the core's enable pulses at 1x, 5x or 20x the host rate. In 1x the core advances only in free slow cycles. While the core is held for the slow bus, a stretch output asks for the low phase of the host clock to be extended.

Top module: `turbo_replay_arb`

## Requirements
- R1: After reset the queue is empty and no host cycle is driven. The block is in 1x mode, and `f_stall` stays high with `f_ce` low until the first `phase_stb` pulse has been seen.
- R2: A host cycle (`h_valid` high) lasts exactly one clock. It appears in the clock right after a `phase_stb` cycle in which `dma_busy` was low, and never at any other time. A DMA-busy slow cycle therefore never carries a replayed write.
- R3: Accepted writes are replayed in acceptance order, at most one per free slow cycle. Once the queue has drained, host memory holds the last value written to each address.
- R4: The queue holds QDEPTH (default 8) entries of {address, data}. A write request while the queue is full gets no `f_ce` until an entry has drained.
- R5: A read whose address has upper nibble 0xD is handled in a fixed order. The block first drains every queued write. It then issues the read in the next free slow cycle, latches `h_rdata` in that host cycle, and only afterwards gives `f_ce` with the data on `f_rdata`.
- R6: Reads outside the I/O window, and writes while the queue has room, are accepted at the next pacing tick with no slow-bus wait.
- R7: `speed_sel` is sampled at each `phase_stb` cycle and takes effect from the following clock. The encodings are 00 = 1x, 01 = 5x, and 10 or 11 = 20x. In 20x every clock is a pacing tick. In 5x the ticks are the `phase_stb` cycle and every SLOW_DIV/5 clocks after it. In 1x the only ticks are `phase_stb` cycles with `dma_busy` low.
- R8: `h_stretch` is high exactly when the core waits on the slow bus: a full-queue write, or an I/O read whose data is not yet back. `f_ce` is never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Speed ratio select |
| phase_stb | input | 1 | One-clock pulse marking each slow-cycle edge, already synchronised |
| dma_busy | input | 1 | Video DMA owns the current slow cycle |
| f_req | input | 1 | Core access request |
| f_we | input | 1 | Core access is a write |
| f_addr | input | AW | Core address |
| f_wdata | input | DW | Core write data |
| f_rdata | output | DW | Data returned for an I/O-window read |
| f_ce | output | 1 | Core advance pulse; an access is taken when high with f_req |
| f_stall | output | 1 | Core held |
| h_valid | output | 1 | Host bus cycle this clock |
| h_we | output | 1 | Host cycle is a write |
| h_addr | output | AW | Host address |
| h_wdata | output | DW | Host write data |
| h_rdata | input | DW | Host read data, valid during a host read cycle |
| h_stretch | output | 1 | Request to stretch the low phase of the host clock |

## Verification
The hardest case to reach is an I/O read arriving while the queue is full and the video DMA window is active. Only in that case does the drain-before-read order matter. It also stacks the longest waits on top of each other. The stimulus issues a burst of writes longer than the queue just before the 40-cycle busy run of the 63-cycle line. It then follows the burst at once with a read of an address it has just written. A cycle-by-cycle reference model, built on queues, checks every pacing tick, host cycle and returned byte against the design.

// File: rtl/trb_pkg.sv
package trb_pkg;

  typedef enum logic [1:0] {
    SPD_1X  = 2'd0,
    SPD_5X  = 2'd1,
    SPD_20X = 2'd2
  } spd_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_WAIT = 2'd1,
    RD_DONE = 2'd2
  } rdst_e;

  function automatic spd_e decode_speed(input logic [1:0] sel);
    case (sel)
      2'd0:    return SPD_1X;
      2'd1:    return SPD_5X;
      default: return SPD_20X;
    endcase
  endfunction

endpackage

// File: rtl/trb_wqueue.sv
module trb_wqueue #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (!push && pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; only the pointers qualify it
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/trb_pace.sv
module trb_pace
  import trb_pkg::*;
#(
  parameter int SLOW_DIV = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_stb,
  input  logic       dma_busy,
  input  logic [1:0] speed_sel,
  output logic       tick,
  output spd_e       mode,
  output logic       seen
);
  localparam int MID_DIV = (SLOW_DIV / 5 > 0) ? SLOW_DIV / 5 : 1;
  localparam int CW      = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;

  spd_e          mode_q, mode_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          raw_tick;

  always_comb begin
    cnt_inc = (cnt_q == CW'(MID_DIV - 1)) ? '0 : cnt_q + CW'(1);
    cnt_d   = phase_stb ? CW'(1 % MID_DIV) : cnt_inc;
    mode_d  = phase_stb ? decode_speed(speed_sel) : mode_q;
    seen_d  = seen_q | phase_stb;
    case (mode_q)
      SPD_1X:  raw_tick = phase_stb & ~dma_busy;
      SPD_5X:  raw_tick = phase_stb | (cnt_q == '0);
      default: raw_tick = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SPD_1X;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tick = raw_tick & seen_q;
  assign mode = mode_q;
  assign seen = seen_q;

endmodule

// File: rtl/trb_slot_seq.sv
module trb_slot_seq
  import trb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_stb,
  input  logic          dma_busy,
  input  logic          seen,
  input  logic          q_empty,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  input  logic          io_rd_req,
  input  logic [AW-1:0] req_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] h_rdata,
  output logic          pop,
  output logic          h_valid,
  output logic          h_we,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_wdata,
  output rdst_e         rd_st,
  output logic [DW-1:0] rd_data
);
  logic          slot, issue_wr, issue_rd, bus_ld, rd_cap, rd_addr_ld;
  logic          hv_q, hwe_q;
  logic [AW-1:0] haddr_q, haddr_d, rd_addr_q;
  logic [DW-1:0] hdata_q, rd_data_q;
  rdst_e         st_q, st_d;

  always_comb begin
    slot       = phase_stb & ~dma_busy;
    issue_wr   = slot & ~q_empty;
    issue_rd   = slot & q_empty & (st_q == RD_WAIT);
    bus_ld     = issue_wr | issue_rd;
    haddr_d    = issue_wr ? q_addr : rd_addr_q;
    rd_cap     = hv_q & ~hwe_q;
    rd_addr_ld = 1'b0;
    st_d       = st_q;
    case (st_q)
      RD_IDLE: if (io_rd_req && seen) begin
        st_d       = RD_WAIT;
        rd_addr_ld = 1'b1;
      end
      RD_WAIT: if (rd_cap) st_d = RD_DONE;
      RD_DONE: if (rd_ack) st_d = RD_IDLE;
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q  <= 1'b0;
      hwe_q <= 1'b0;
      st_q  <= RD_IDLE;
    end else begin
      hv_q  <= bus_ld;
      hwe_q <= issue_wr;
      st_q  <= st_d;
    end
  end

  // payload registers with explicit enables, no reset needed
  always_ff @(posedge clk) begin
    if (bus_ld)     haddr_q   <= haddr_d;
    if (issue_wr)   hdata_q   <= q_data;
    if (rd_addr_ld) rd_addr_q <= req_addr;
    if (rd_cap)     rd_data_q <= h_rdata;
  end

  assign pop     = issue_wr;
  assign h_valid = hv_q;
  assign h_we    = hwe_q;
  assign h_addr  = haddr_q;
  assign h_wdata = hdata_q;
  assign rd_st   = st_q;
  assign rd_data = rd_data_q;

endmodule

// File: rtl/turbo_replay_arb.sv
module turbo_replay_arb
  import trb_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter int            QDEPTH   = 8,
  parameter int            SLOW_DIV = 20,
  parameter logic [AW-1:0] IO_BASE  = 16'hD000,
  parameter logic [AW-1:0] IO_MASK  = 16'hF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed_sel,
  input  logic          phase_stb,
  input  logic          dma_busy,
  input  logic          f_req,
  input  logic          f_we,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_wdata,
  output logic [DW-1:0] f_rdata,
  output logic          f_ce,
  output logic          f_stall,
  output logic          h_valid,
  output logic          h_we,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_wdata,
  input  logic [DW-1:0] h_rdata,
  output logic          h_stretch
);
  localparam int EW = AW + DW;

  logic          rs_meta, rst_sync_n;
  logic          tick, seen, q_empty, q_full, push, pop;
  logic          io_rd_req, wait_slow, block, rd_ack;
  logic [EW-1:0] q_head;
  spd_e          mode_q;
  rdst_e         rd_st;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  always_comb begin
    io_rd_req = f_req & ~f_we & ((f_addr & IO_MASK) == IO_BASE);
    wait_slow = (f_req & f_we & q_full) | (io_rd_req & (rd_st != RD_DONE));
    block     = ~seen | wait_slow;
    f_ce      = tick & ~block;
    rd_ack    = f_ce & io_rd_req;
    push      = f_ce & f_req & f_we;
  end

  trb_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
    .clk(clk), .rst_n(rst_sync_n), .phase_stb(phase_stb), .dma_busy(dma_busy),
    .speed_sel(speed_sel), .tick(tick), .mode(mode_q), .seen(seen)
  );

  trb_wqueue #(.WIDTH(EW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .push_data({f_addr, f_wdata}),
    .pop(pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  trb_slot_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .phase_stb(phase_stb), .dma_busy(dma_busy),
    .seen(seen), .q_empty(q_empty), .q_addr(q_head[EW-1:DW]), .q_data(q_head[DW-1:0]),
    .io_rd_req(io_rd_req), .req_addr(f_addr), .rd_ack(rd_ack), .h_rdata(h_rdata),
    .pop(pop), .h_valid(h_valid), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .rd_st(rd_st), .rd_data(f_rdata)
  );

  assign f_stall   = block;
  assign h_stretch = wait_slow;

endmodule

// File: rtl/turbo_replay_arb_chk.sv
module turbo_replay_arb_chk
  import trb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic phase_stb,
  input logic dma_busy,
  input logic f_req,
  input logic f_we,
  input logic f_ce,
  input logic h_valid,
  input logic h_we,
  input logic h_stretch,
  input spd_e mode,
  input logic q_full,
  input logic q_empty
);
  logic ck_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_seen <= 1'b0;
    else if (phase_stb) ck_seen <= 1'b1;
  end

  a_r1_no_ce_before_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_seen |-> !f_ce);

  a_r2_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> $past(phase_stb && !dma_busy));

  a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |=> !h_valid);

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && f_we && q_full) |-> !f_ce);

  a_r5_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !h_we) |-> q_empty);

  a_r7_lockstep_pace: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SPD_1X && f_ce) |-> (phase_stb && !dma_busy));

  a_r8_stretch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    h_stretch |-> !f_ce);

endmodule

bind turbo_replay_arb turbo_replay_arb_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .phase_stb(phase_stb), .dma_busy(dma_busy),
  .f_req(f_req), .f_we(f_we), .f_ce(f_ce), .h_valid(h_valid), .h_we(h_we),
  .h_stretch(h_stretch), .mode(mode_q), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/turbo_replay_arb_bench.sv
`timescale 1ns/1ps
module turbo_replay_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  speed_sel;
  logic        phase_stb, dma_busy;
  logic        f_req, f_we;
  logic [15:0] f_addr;
  logic [7:0]  f_wdata, f_rdata;
  logic        f_ce, f_stall, h_valid, h_we, h_stretch;
  logic [15:0] h_addr;
  logic [7:0]  h_wdata, h_rdata;

  int n_chk = 0, n_fail = 0;
  bit run_phase = 0, finished = 0;
  logic [7:0] hmem [int];
  logic [7:0] exp_mem [int];

  always #5 clk = ~clk;

  turbo_replay_arb u_turbo_replay_arb (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .phase_stb(phase_stb),
    .dma_busy(dma_busy), .f_req(f_req), .f_we(f_we), .f_addr(f_addr),
    .f_wdata(f_wdata), .f_rdata(f_rdata), .f_ce(f_ce), .f_stall(f_stall),
    .h_valid(h_valid), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_stretch(h_stretch)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slow-cycle and DMA pattern: 20 clocks per slow cycle, 63 per line, 40 busy
  int pcnt = 0, lidx = 10;
  always @(posedge clk) begin
    #1;
    if (run_phase) begin
      phase_stb = (pcnt == 0);
      if (pcnt == 0) begin
        dma_busy = (lidx >= 15 && lidx < 55);
        lidx = (lidx == 62) ? 0 : lidx + 1;
      end
      pcnt = (pcnt == 19) ? 0 : pcnt + 1;
    end
  end

  // host memory
  always @(negedge clk) begin
    if (h_valid && h_we) begin
      check(!dma_busy, "R2", "write in DMA slow cycle", 1, 0);
      hmem[int'(h_addr)] = h_wdata;
    end
  end
  always @(posedge clk) begin
    #2;
    if (h_valid && !h_we) h_rdata = hmem.exists(int'(h_addr)) ? hmem[int'(h_addr)] : 8'h00;
    else h_rdata = 8'h00;
  end

  // behavioural reference model, compared every clock
  int   mq[$];
  logic [7:0] mm [int];
  bit   m_seen, m_hv, m_hwe;
  int   m_mode, m_off, m_rd, m_rdaddr, m_haddr, m_hdata, m_rddata;
  always @(negedge clk) begin : model
    bit slot, tick, iord, full, wfull, wt, blk, ce, iss_wr, iss_rd;
    int nrd;
    if (!rst_n) begin
      mq.delete(); m_seen = 0; m_hv = 0; m_hwe = 0; m_mode = 0; m_off = 0; m_rd = 0;
    end else begin
      slot  = phase_stb && !dma_busy;
      tick  = m_seen && ((m_mode == 0) ? slot : (m_mode == 1) ? (phase_stb || (m_off % 4 == 0)) : 1'b1);
      iord  = f_req && !f_we && (f_addr[15:12] == 4'hD);
      full  = (mq.size() == 8);
      wfull = f_req && f_we && full;
      wt    = wfull || (iord && m_rd != 2);
      blk   = !m_seen || wt;
      ce    = tick && !blk;
      check(f_ce == ce, "R7", "f_ce", f_ce, ce);
      check(f_stall == blk, "R4", "f_stall", f_stall, blk);
      check(h_stretch == wt, "R8", "h_stretch", h_stretch, wt);
      check(h_valid == m_hv, "R2", "h_valid", h_valid, m_hv);
      if (m_hv) begin
        check(h_we == m_hwe, "R2", "h_we", h_we, m_hwe);
        check(int'(h_addr) == m_haddr, "R3", "h_addr", h_addr, m_haddr);
        if (m_hwe) check(int'(h_wdata) == m_hdata, "R3", "h_wdata", h_wdata, m_hdata);
      end
      if (m_rd == 2) check(int'(f_rdata) == m_rddata, "R5", "f_rdata", f_rdata, m_rddata);
      // next state
      iss_wr = slot && mq.size() > 0;
      iss_rd = slot && mq.size() == 0 && m_rd == 1;
      nrd = m_rd;
      if (m_rd == 0 && iord && m_seen) begin nrd = 1; m_rdaddr = int'(f_addr); end
      else if (m_rd == 1 && m_hv && !m_hwe) begin
        nrd = 2; m_rddata = mm.exists(m_haddr) ? int'(mm[m_haddr]) : 0;
      end else if (m_rd == 2 && ce && iord) nrd = 0;
      if (m_hv && m_hwe) mm[m_haddr] = 8'(m_hdata);
      if (iss_wr) begin
        m_haddr = mq[0] >> 8; m_hdata = mq[0] & 8'hFF; void'(mq.pop_front());
      end else if (iss_rd) m_haddr = m_rdaddr;
      m_hv = iss_wr || iss_rd; m_hwe = iss_wr;
      if (ce && f_req && f_we) mq.push_back((int'(f_addr) << 8) | int'(f_wdata));
      m_rd = nrd;
      if (phase_stb) m_mode = (speed_sel == 2'd0) ? 0 : (speed_sel == 2'd1) ? 1 : 2;
      m_seen = m_seen || phase_stb;
      m_off = phase_stb ? 1 : m_off + 1;
    end
  end

  time acc_t;
  task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int waits);
    waits = 0; f_req = 1; f_we = we; f_addr = a; f_wdata = d;
    forever begin
      @(negedge clk);
      if (f_ce) begin rd = f_rdata; break; end
      waits++;
    end
    acc_t = $time;
    if (we) exp_mem[int'(a)] = d;
    @(posedge clk); #1; f_req = 0; f_we = 0;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int w, maxw;
    time t0;
    rst_n = 0; speed_sel = 2'd2; phase_stb = 0; dma_busy = 0;
    f_req = 0; f_we = 0; f_addr = 0; f_wdata = 0; h_rdata = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1: held before the first phase edge, even with a request pending
    f_req = 1; f_we = 1; f_addr = 16'h1000; f_wdata = 8'h11;
    repeat (8) begin
      @(negedge clk);
      check(f_stall && !f_ce && !h_valid && !h_stretch, "R1", "pre-phase state",
            {f_stall, f_ce, h_valid, h_stretch}, 4'b1000);
    end
    @(posedge clk); #1 f_req = 0; f_we = 0;
    run_phase = 1;
    repeat (45) @(posedge clk); #1;
    // 20x burst longer than the queue, into the DMA window
    maxw = 0;
    for (int i = 0; i < 30; i++) begin
      acc(1, 16'h0400 + 16'(i), 8'(i * 7 + 3), rd, w);
      if (w > maxw) maxw = w;
    end
    check(maxw > 0, "R4", "full queue stalled a write", maxw, 1);
    acc(1, 16'hD020, 8'h5A, rd, w);
    acc(0, 16'hD020, 8'h00, rd, w);
    check(rd == 8'h5A, "R5", "io read after write", rd, 8'h5A);
    acc(1, 16'hD021, 8'h33, rd, w);
    acc(1, 16'h0400, 8'hEE, rd, w);
    acc(0, 16'hD021, 8'h00, rd, w);
    check(rd == 8'h33, "R5", "io read second", rd, 8'h33);
    acc(0, 16'h2000, 8'h00, rd, w);
    check(w == 0, "R6", "local read wait 20x", w, 0);
    // 5x
    speed_sel = 2'd1;
    repeat (45) @(posedge clk); #1;
    for (int i = 0; i < 12; i++) acc(1, 16'h0800 + 16'(i), 8'(8'hA0 + i), rd, w);
    acc(0, 16'hD020, 8'h00, rd, w);
    check(rd == 8'h5A, "R5", "io read 5x", rd, 8'h5A);
    acc(0, 16'h3000, 8'h00, rd, w);
    check(w <= 3, "R7", "5x local read wait", w, 3);
    // 1x lockstep
    speed_sel = 2'd0;
    repeat (45) @(posedge clk); #1;
    for (int i = 0; i < 5; i++) acc(1, 16'h0C00 + 16'(i), 8'(8'h40 + i), rd, w);
    acc(1, 16'hD018, 8'h77, rd, w);
    acc(0, 16'hD018, 8'h00, rd, w);
    check(rd == 8'h77, "R5", "io read 1x", rd, 8'h77);
    acc(0, 16'h4000, 8'h00, rd, w);
    t0 = acc_t;
    acc(0, 16'h4001, 8'h00, rd, w);
    check((acc_t - t0) >= 200, "R7", "1x spacing ns", int'(acc_t - t0), 200);
    check(w > 0, "R6", "1x read waits for a slot", w, 1);
    // drain and compare host memory
    repeat (3000) @(posedge clk);
    foreach (exp_mem[a])
      check(hmem.exists(a) && hmem[a] == exp_mem[a], "R3", "final memory",
            hmem.exists(a) ? int'(hmem[a]) : -1, exp_mem[a]);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule